// File: doc/BRIEF.md
# Lockstep Transmit Ready and DMA Request Logic

This block handles the transmit side of a multi-lane audio serial port. Several transmit lanes run in lockstep on one bit clock. Each lane has a holding buffer that software fills through a small register write port, and a shift register that sends the word MSB-first. After every N bit clocks, all holding buffers move into their shift registers at the same moment. That moment is the transfer.

Each transfer sets a single "buffers empty" status flag that covers all lanes. It also produces exactly one DMA request pulse in the system-clock domain, even when software has never cleared the flag. The transfer event crosses from the bit-clock domain to the system-clock domain through a toggle synchronizer. After that, a delay of DLY system clocks (1 to 5) is added before the request appears at the boundary.

The flag can be cleared in two ways. Software can write a 1 to the status address. The flag also clears by itself once every enabled lane's buffer has been refilled since the last transfer. A maskable interrupt output follows the flag.

Top module: `txs_ready_top`

## Requirements
- R1: While reset is asserted, and after its release until the first transfer, `ready`, `irq`, `dma_req` and every `ser_dout` bit are 0.
- R2: The first transfer happens at the N-th rising edge of `bclk` after reset release, and then at every N-th rising edge. From each transfer edge, every enabled lane drives its loaded word MSB first, one bit per `bclk` period, changing on rising edges.
- R3: A lane whose `ser_en` bit is 0 drives `ser_dout` low.
- R4: Every transfer sets `ready`. The flag is 1 no later than the cycle in which the matching `dma_req` pulse is high.
- R5: A write to address NSER (status) with `wr_data[0]`=1 clears `ready`. The same write with `wr_data[0]`=0 leaves `ready` unchanged.
- R6: `ready` clears when every lane with `ser_en`=1 has had its buffer written since the last transfer. Writes that cover only part of the enabled lanes, writes made before the transfer, and writes to disabled lanes leave `ready` set. With `ser_en` all zero, the flag never auto-clears.
- R7: Each transfer produces exactly one `dma_req` pulse, one system clock wide. This holds whatever the state of `ready`.
- R8: `dma_req` rises between DLY+1 and DLY+3 system clocks after the `bclk` edge that made the transfer.
- R9: `irq` is 1 exactly when `ready` is 1 and the interrupt enable (address NSER+1, bit 0) is 1. It follows changes to either one within one system clock.
- R10: A write to address s, with s < NSER, loads `wr_data` into the buffer of lane s. That word is shifted out on lane s from the next transfer onward until the buffer is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bclk | input | 1 | Serial bit clock |
| wr_en | input | 1 | Register write strobe (system clock) |
| wr_addr | input | $clog2(NSER+2) | Write address: lane buffers, then status, then control |
| wr_data | input | N | Write data |
| ser_en | input | NSER | Per-lane transmit enable |
| ser_dout | output | NSER | Serial data per lane |
| ready | output | 1 | Buffers-empty status flag |
| irq | output | 1 | Masked interrupt |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
If the slot counter or a shift register holds the wrong state, a lane shows a misordered or stale word within one slot of N bit clocks. If the toggle or its synchronizer stages go wrong, the request is either missing or doubled, or it is late by more than the allowed window; this shows up in the first transfer after the fault. If the written-lane mask goes wrong, `ready` either drops early after a partial refill or stays high after a full refill. That is visible a few system clocks after the last buffer write. If the flag or the interrupt enable goes wrong, `irq` disagrees with `ready` within one system clock.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_BUF,
        ACC_STAT,
        ACC_CTRL
    } acc_e;

    localparam int FLAG_BIT = 0;
    localparam int IEN_BIT  = 0;
endpackage

// File: rtl/txs_slot_timer.sv
module txs_slot_timer #(
    parameter int N = 8
) (
    input  logic bclk,
    input  logic rst_n,
    output logic load_o,
    output logic tgl_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tgl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.tgl = ~st_q.tgl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o = (st_q.cnt == LAST);
    assign tgl_o  = st_q.tgl;

    // R2
    slot_wrap_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        load_o |=> (st_q.cnt == '0) && (tgl_o != $past(tgl_o)));
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
    parameter int N = 8
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] word_i,
    input  logic         en_i,
    output logic         dout_o
);
    typedef struct packed {
        logic [N-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.sh = word_i;
        else        st_d.sh = {st_q.sh[N-2:0], 1'b0};
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o = en_i & st_q.sh[N-1];

    // R10
    shift_load_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        load_i |=> st_q.sh == $past(word_i));
    // R3
    lane_quiet_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !en_i |-> !dout_o);
endmodule

// File: rtl/txs_req_sync.sv
module txs_req_sync #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic evt_o,
    output logic req_o
);
    typedef struct packed {
        logic [2:0]     sync;
        logic [DLY-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], tgl_i};
        if (DLY > 1) st_d.pipe = {st_q.pipe[DLY-2:0], evt_o};
        else         st_d.pipe = DLY'(evt_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.sync[1] ^ st_q.sync[2];
    assign req_o = st_q.pipe[DLY-1];

    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R8
    req_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ##DLY req_o);
endmodule

// File: rtl/txs_ready_top.sv
module txs_ready_top #(
    parameter int N    = 8,
    parameter int NSER = 4,
    parameter int DLY  = 3,
    localparam int AW  = $clog2(NSER + 2),
    localparam int IW  = (NSER > 1) ? $clog2(NSER) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [N-1:0]    wr_data,
    input  logic [NSER-1:0] ser_en,
    output logic [NSER-1:0] ser_dout,
    output logic            ready,
    output logic            irq,
    output logic            dma_req
);
    import txs_pkg::*;

    typedef struct packed {
        logic [NSER-1:0][N-1:0] bufs;
        logic [NSER-1:0]        wrt;
        logic                   rdy;
        logic                   ien;
        logic                   irq;
    } st_t;

    st_t  st_d, st_q;
    acc_e acc;
    logic all_wr;
    logic evt;
    logic load;
    logic tgl;

    txs_slot_timer #(.N(N)) u_timer (
        .bclk   (bclk),
        .rst_n  (rst_n),
        .load_o (load),
        .tgl_o  (tgl)
    );

    txs_req_sync #(.DLY(DLY)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl_i (tgl),
        .evt_o (evt),
        .req_o (dma_req)
    );

    for (genvar g = 0; g < NSER; g++) begin : g_lane
        txs_shifter #(.N(N)) u_shift (
            .bclk   (bclk),
            .rst_n  (rst_n),
            .load_i (load),
            .word_i (st_q.bufs[g]),
            .en_i   (ser_en[g]),
            .dout_o (ser_dout[g])
        );
    end

    always_comb begin
        if (!wr_en)                          acc = ACC_NONE;
        else if (wr_addr < AW'(NSER))        acc = ACC_BUF;
        else if (wr_addr == AW'(NSER))       acc = ACC_STAT;
        else if (wr_addr == AW'(NSER + 1))   acc = ACC_CTRL;
        else                                 acc = ACC_NONE;
    end

    always_comb begin
        st_d = st_q;
        case (acc)
            ACC_BUF: begin
                st_d.bufs[wr_addr[IW-1:0]] = wr_data;
                st_d.wrt[wr_addr[IW-1:0]]  = 1'b1;
            end
            ACC_STAT: if (wr_data[FLAG_BIT]) st_d.rdy = 1'b0;
            ACC_CTRL: st_d.ien = wr_data[IEN_BIT];
            default: ;
        endcase
        all_wr = (ser_en != '0) && (&(st_d.wrt | ~ser_en));
        if (st_q.rdy && all_wr) st_d.rdy = 1'b0;
        if (evt) begin
            st_d.rdy = 1'b1;
            st_d.wrt = '0;
        end
        st_d.irq = st_d.rdy & st_d.ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.rdy;
    assign irq   = st_q.irq;

    // R4
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ready);
    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_STAT) && wr_data[FLAG_BIT] && !evt |=> !ready);
    // R6
    partial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !evt && !all_wr && (acc != ACC_STAT) |=> ready);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);
    // R6
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> st_q.wrt == '0 || $past(acc == ACC_NONE) == 1'b0);
endmodule

// File: tb/txs_ready_top_tb.sv
module txs_ready_top_tb;
    localparam int N    = 8;
    localparam int NSER = 4;
    localparam int DLY  = 3;
    localparam int AW   = $clog2(NSER + 2);

    // {en[11:8], wmask[7:4], w1c[3], ien[2], exp_ready[1], exp_irq[0]}
    localparam logic [11:0] VEC [0:6] = '{
        12'hFF4, 12'hF77, 12'hF0C, 12'hBB4, 12'hB32, 12'hF07, 12'h0F2
    };

    logic            clk = 0;
    logic            bclk = 0;
    logic            rst_n = 0;
    logic            wr_en = 0;
    logic [AW-1:0]   wr_addr = '0;
    logic [N-1:0]    wr_data = '0;
    logic [NSER-1:0] ser_en = '1;
    logic [NSER-1:0] ser_dout;
    logic            ready, irq, dma_req;

    int n_chk = 0;
    int n_fail = 0;
    int pcnt = 0;
    int bidx = 0;
    bit collecting = 0;
    bit bnd_pending = 0;
    int lat = 0;
    int dma_cnt = 0;
    bit dma_prev = 0;
    logic [N-1:0] mbuf [NSER];
    logic [N-1:0] snap [NSER];
    logic [N-1:0] got  [NSER];
    logic [N-1:0] expw [NSER];

    txs_ready_top #(.N(N), .NSER(NSER), .DLY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ser_en(ser_en),
        .ser_dout(ser_dout), .ready(ready), .irq(irq), .dma_req(dma_req)
    );

    always #5 clk = ~clk;
    initial begin
        #3;
        forever #20 bclk = ~bclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] dat(input int i, input int s);
        return N'(8'hA5 ^ (i * 37) ^ (s * 8'h5B));
    endfunction

    // slot boundaries and serial capture (R2, R3, R10)
    always @(posedge bclk) begin
        if (rst_n) begin
            pcnt++;
            if (pcnt % N == 0) begin
                for (int s = 0; s < NSER; s++) snap[s] = mbuf[s];
                bidx = 0;
                collecting = 1;
                bnd_pending = 1;
                lat = 0;
            end
        end
    end

    always @(negedge bclk) begin
        if (rst_n && collecting) begin
            for (int s = 0; s < NSER; s++) begin
                got[s][N-1-bidx]  = ser_dout[s];
                expw[s][N-1-bidx] = ser_en[s] ? snap[s][N-1-bidx] : 1'b0;
            end
            bidx++;
            if (bidx == N) begin
                for (int s = 0; s < NSER; s++)
                    check(got[s] == expw[s], "R2/R3/R10 lane word", int'(got[s]), int'(expw[s]));
                collecting = 0;
            end
        end
    end

    // DMA pulse monitor (R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (bnd_pending) lat++;
            if (dma_req) begin
                if (dma_prev) check(0, "R7 pulse width", 2, 1);
                else begin
                    dma_cnt++;
                    if (bnd_pending) begin
                        check(lat >= DLY + 1 && lat <= DLY + 3, "R8 latency", lat, DLY + 2);
                        bnd_pending = 0;
                    end else check(0, "R7 request without transfer", 1, 0);
                end
            end
            dma_prev = dma_req;
        end
    end

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
        if (a < NSER) mbuf[a] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    int seen = 0;
    task automatic wait_evt();
        int t = 0;
        check(dma_cnt == seen, "R7 extra pulse in slot", dma_cnt, seen);
        while (dma_cnt == seen && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(dma_cnt == seen + 1, "R7 one pulse per transfer", dma_cnt, seen + 1);
        seen = dma_cnt;
        check(ready == 1'b1, "R4 ready set on transfer", ready, 1);
    endtask

    initial begin
        #300_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSER; s++) mbuf[s] = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check({ready, irq, dma_req} == 3'b000, "R1 flags in reset", {ready, irq, dma_req}, 0);
        check(ser_dout == '0, "R1 lanes in reset", ser_dout, 0);
        @(negedge clk);
        rst_n = 1;
        for (int s = 0; s < NSER; s++) wr(s, dat(100, s));
        check({ready, irq, dma_req} == 3'b000, "R1 flags before transfer", {ready, irq, dma_req}, 0);
        check(ser_dout == '0, "R1 lanes before transfer", ser_dout, 0);
        wait_evt();

        for (int i = 0; i < 7; i++) begin
            logic [11:0] v;
            v = VEC[i];
            @(negedge clk);
            ser_en = v[11:8];
            wr(NSER + 1, N'(v[2]));
            if (v[3]) wr(NSER, N'(1));
            for (int s = 0; s < NSER; s++)
                if (v[4 + s]) wr(s, dat(i, s));
            repeat (2) @(negedge clk);
            check(ready == v[1], "R5/R6 ready after vector", ready, v[1]);
            check(irq == v[0], "R9 irq after vector", irq, v[0]);
            wait_evt();
        end

        // Directed: status write with bit 0 clear has no effect (R5)
        @(negedge clk);
        ser_en = '1;
        wr(NSER + 1, N'(1));
        wr(NSER, N'(2));
        @(negedge clk);
        check(ready == 1'b1, "R5 zero write keeps flag", ready, 1);
        check(irq == 1'b1, "R9 irq with flag set", irq, 1);
        wr(NSER + 1, N'(0));
        @(negedge clk);
        check(irq == 1'b0, "R9 irq masked", irq, 0);
        wr(NSER, N'(1));
        @(negedge clk);
        check(ready == 1'b0, "R5 write-one clears", ready, 0);
        // writes before a transfer do not count (R6)
        for (int s = 0; s < NSER; s++) wr(s, dat(50, s));
        wait_evt();
        repeat (2) @(negedge clk);
        check(ready == 1'b1, "R6 pre-transfer writes ignored", ready, 1);
        for (int s = 0; s < NSER - 1; s++) wr(s, dat(60, s));
        @(negedge clk);
        check(ready == 1'b1, "R6 partial refill keeps flag", ready, 1);
        wr(NSER - 1, dat(60, NSER - 1));
        @(negedge clk);
        check(ready == 1'b0, "R6 full refill clears", ready, 0);
        wait_evt();
        repeat (2 * N * 4 + 10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule